// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for a single read or write burst in a synchronous DRAM controller. Each accepted column command supplies a start column, a burst-length code and an ordering choice. From the next clock on, the block emits one column address per cycle until the burst runs out, a stop request ends it, or a newer column command replaces it.

Two orderings are available. The sequential ordering counts upward inside the aligned block that the burst length defines, and wraps within that block. The interleave ordering XORs the beat number into the low bits of the start column. A full-page length counts through every column of the row, wrapping from the highest column to zero. It continues until stopped and never reports a final beat.

Top module: `burst_col_gen`

## Requirements
- R1: Out of reset `burstActive` is 0, `lastBeat` is 0 and `colAddr` is 0.
- R2: When `cmdValid` is high at a rising edge, the next cycle shows `burstActive` = 1 and `colAddr` equal to the `startCol` captured at that edge (beat 0).
- R3: `lenCode` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Codes 4, 5 and 6 act as 1 beat. A fixed-length burst stays active for exactly that many cycles. `lastBeat` is high only on its final beat, and `burstActive` is 0 in the cycle after it.
- R4: With `ilvMode` = 0 and burst length N, beat k outputs floor(start/N)*N + ((start mod N) + k) mod N.
- R5: With `ilvMode` = 1 and burst length N of 8 or less, beat k outputs floor(start/N)*N + ((start mod N) XOR k).
- R6: `lenCode` = 7 selects full page. Beat k outputs (start + k) mod 512. `lastBeat` stays 0, and the burst runs until a stop request or a new command.
- R7: `ilvMode` is ignored in full-page mode, which always counts sequentially.
- R8: `stopReq` high at an edge during an active burst, without `cmdValid`, makes the next cycle inactive with `colAddr` = 0.
- R9: `cmdValid` during a running burst restarts the burst at the new start column on the next cycle, even when `stopReq` is high at the same edge.
- R10: While idle, `colAddr` and `lastBeat` are 0, and `stopReq` has no effect.
- R11: Commands on consecutive clocks each restart the burst, so the output shows each new start column one cycle after its command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Column command accepted this cycle |
| startCol | input | 9 | Start column of the command |
| lenCode | input | 3 | Burst length code (0..3 = 1,2,4,8; 7 = full page) |
| ilvMode | input | 1 | 1 = interleave ordering, 0 = sequential |
| stopReq | input | 1 | Ends the running burst |
| colAddr | output | 9 | Column address of the current beat, 0 when idle |
| burstActive | output | 1 | A beat is being emitted this cycle |
| lastBeat | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench uses the default 9-bit column width, which gives a 512-column page. At that width a full-page run that starts two columns below the top of the page reaches the 511-to-0 wrap within a few cycles. The stimulus table covers every burst length under both orderings. Its start columns have nonzero upper bits and are unaligned, so an upper bit that leaks or a wrap that is missing changes the address the bench sees.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_BITS = 9;
  localparam int LEN_BITS = 3;
  localparam logic [LEN_BITS-1:0] FULL_PAGE = 3'd7;

  typedef struct packed {
    logic                load;
    logic                show;
    logic [COL_BITS-1:0] mask;
  } colStrobe_t;

  function automatic logic [COL_BITS-1:0] lenMaskOf(input logic [LEN_BITS-1:0] code);
    logic [COL_BITS-1:0] m;
    case (code)
      3'd1:    m = COL_BITS'(1);
      3'd2:    m = COL_BITS'(3);
      3'd3:    m = COL_BITS'(7);
      3'd7:    m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmdValid,
  input  logic                stopReq,
  input  logic [LEN_BITS-1:0] lenCode,
  output colStrobe_t          strobes,
  output logic [COL_BITS-1:0] beatIdx,
  output logic                burstActive,
  output logic                lastBeat
);
  logic                active;
  logic                fullReg;
  logic [COL_BITS-1:0] maskReg;
  logic [COL_BITS-1:0] beatReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      fullReg <= 1'b0;
      maskReg <= '0;
      beatReg <= '0;
    end else if (cmdValid) begin
      active  <= 1'b1;
      fullReg <= (lenCode == FULL_PAGE);
      maskReg <= lenMaskOf(lenCode);
      beatReg <= '0;
    end else if (active) begin
      if (stopReq || lastBeat) active <= 1'b0;
      else beatReg <= beatReg + 1'b1;
    end
  end

  always_comb begin
    lastBeat     = active && !fullReg && (beatReg == maskReg);
    burstActive  = active;
    beatIdx      = beatReg;
    strobes.load = cmdValid;
    strobes.show = active;
    strobes.mask = maskReg;
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> (burstActive && beatIdx == '0));
  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burstActive && stopReq && !cmdValid) |=> !burstActive);
  // R3
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !cmdValid) |=> !burstActive);
  // R6
  full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burstActive && fullReg && !stopReq && !cmdValid) |=> burstActive);
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  colStrobe_t          strobes,
  input  logic [COL_BITS-1:0] beatIdx,
  input  logic [COL_BITS-1:0] startCol,
  input  logic [LEN_BITS-1:0] lenCode,
  input  logic                ilvMode,
  output logic [COL_BITS-1:0] colAddr
);
  logic [COL_BITS-1:0] baseReg;
  logic                ilvReg;
  logic [COL_BITS-1:0] seqAddr;
  logic [COL_BITS-1:0] ilvAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseReg <= '0;
      ilvReg  <= 1'b0;
    end else if (strobes.load) begin
      baseReg <= startCol;
      ilvReg  <= ilvMode && (lenCode != FULL_PAGE);
    end
  end

  always_comb begin
    seqAddr = (baseReg & ~strobes.mask) | ((baseReg + beatIdx) & strobes.mask);
    ilvAddr = (baseReg & ~strobes.mask) | ((baseReg ^ beatIdx) & strobes.mask);
    if (!strobes.show) colAddr = '0;
    else if (ilvReg)   colAddr = ilvAddr;
    else               colAddr = seqAddr;
  end

  // R2
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (colAddr == $past(startCol)));
  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.show && !strobes.load) |=>
      (!strobes.show || ((colAddr & ~strobes.mask) == ($past(colAddr) & ~$past(strobes.mask)))));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmdValid,
  input  logic [COL_BITS-1:0] startCol,
  input  logic [LEN_BITS-1:0] lenCode,
  input  logic                ilvMode,
  input  logic                stopReq,
  output logic [COL_BITS-1:0] colAddr,
  output logic                burstActive,
  output logic                lastBeat
);
  colStrobe_t          strobes;
  logic [COL_BITS-1:0] beatIdx;

  burst_col_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .stopReq(stopReq),
    .lenCode(lenCode), .strobes(strobes), .beatIdx(beatIdx),
    .burstActive(burstActive), .lastBeat(lastBeat)
  );

  burst_col_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .beatIdx(beatIdx),
    .startCol(startCol), .lenCode(lenCode), .ilvMode(ilvMode), .colAddr(colAddr)
  );

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burstActive |-> (colAddr == '0 && !lastBeat));
endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdValid = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       ilvMode = 1'b0;
  logic       stopReq = 1'b0;
  logic [8:0] colAddr;
  logic       burstActive;
  logic       lastBeat;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .startCol(startCol),
    .lenCode(lenCode), .ilvMode(ilvMode), .stopReq(stopReq),
    .colAddr(colAddr), .burstActive(burstActive), .lastBeat(lastBeat)
  );

  // {lenCode, ilvMode, startCol}
  localparam logic [12:0] VEC [10] = '{
    {3'd0, 1'b0, 9'd100}, {3'd1, 1'b0, 9'd5},   {3'd2, 1'b0, 9'h01D},
    {3'd3, 1'b0, 9'h01D}, {3'd1, 1'b1, 9'd3},   {3'd2, 1'b1, 9'h01E},
    {3'd3, 1'b1, 9'h015}, {3'd5, 1'b0, 9'd9},   {3'd3, 1'b1, 9'h106},
    {3'd0, 1'b1, 9'h1FF}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expAddr(input int st, input int n, input bit ilv, input int k);
    int blk = (st / n) * n;
    if (ilv) return blk + ((st % n) ^ k);
    return blk + (((st % n) + k) % n);
  endfunction

  task automatic issue(input int code, input bit ilv, input int st);
    cmdValid = 1'b1; lenCode = 3'(code); ilvMode = ilv; startCol = 9'(st);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 active", burstActive, 0);
    chk("R1 last", lastBeat, 0);
    chk("R1 addr", colAddr, 0);

    foreach (VEC[i]) begin
      int code = int'(VEC[i][12:10]);
      bit ilv = VEC[i][9];
      int st = int'(VEC[i][8:0]);
      int n = (code <= 3) ? (1 << code) : 1;
      issue(code, ilv, st);
      for (int k = 0; k < n; k++) begin
        chk("R3 active", burstActive, 1);
        chk(ilv ? "R5 addr" : "R4 addr", colAddr, expAddr(st, n, ilv, k));
        chk("R3 last", lastBeat, (k == n - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R3 end", burstActive, 0);
      chk("R10 idle addr", colAddr, 0);
    end

    // R6 and R7: full page across the wrap, interleave ignored
    issue(7, 1'b1, 510);
    for (int k = 0; k < 5; k++) begin
      chk("R6 R7 addr", colAddr, (510 + k) % 512);
      chk("R6 last", lastBeat, 0);
      chk("R6 active", burstActive, 1);
      @(negedge clk);
    end
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8 full stop", burstActive, 0);
    chk("R8 addr", colAddr, 0);

    // R8: stop in the middle of a fixed burst
    issue(3, 1'b0, 40);
    chk("R2 start", colAddr, 40);
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8 active", burstActive, 0);
    chk("R8 last", lastBeat, 0);

    // R9: new command wins over a stop in the same cycle
    issue(3, 1'b0, 8);
    @(negedge clk);
    stopReq = 1'b1;
    issue(1, 1'b0, 9'h51);
    stopReq = 1'b0;
    chk("R9 restart addr", colAddr, 9'h51);
    chk("R9 active", burstActive, 1);
    chk("R9 last", lastBeat, 0);
    @(negedge clk);
    chk("R9 wrap addr", colAddr, 9'h50);
    chk("R9 final", lastBeat, 1);
    @(negedge clk);

    // R11: commands on back-to-back clocks
    cmdValid = 1'b1; lenCode = 3'd2; ilvMode = 1'b0;
    for (int s = 1; s <= 3; s++) begin
      startCol = 9'(s * 20);
      @(negedge clk);
      chk("R11 addr", colAddr, s * 20);
    end
    cmdValid = 1'b0;
    @(negedge clk);
    chk("R11 next", colAddr, 61);
    repeat (3) @(negedge clk);

    // R10: stop while idle has no effect
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R10 active", burstActive, 0);
    chk("R10 addr", colAddr, 0);
    issue(1, 1'b0, 7);
    chk("R10 after stop", colAddr, 7);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule